// File: doc/BRIEF.md
# Vector Multiply-Accumulate Accumulator

This block accumulates products of two 128-bit vector operands. Each cycle it accepts one command on a valid strobe. A lane-wise multiply adds each signed lane product into its own slot of a 512-bit wide accumulator. With 8-bit elements that accumulator holds sixteen 32-bit sums, and with 16-bit elements it holds eight 64-bit sums. A scalar-times-vector variant first broadcasts one selected element of the second operand to every lane. A dot-product command multiplies the eight signed 16-bit lane pairs and adds the sum of all eight products into a 40-bit scalar accumulator.

The wide accumulator cannot be read directly. The extract command shifts every lane arithmetically right by the `shamt` input, saturates each shifted value to the current element width, and returns the narrowed lanes as one 128-bit vector. Two independent clear strobes zero the wide and the scalar accumulator. Operand fetch and shift configuration are the job of the surrounding datapath.

Top module: `vmac_accum`

## Requirements
- R1: After a synchronous active-low reset, both accumulators are zero, `ext_vec` is zero and `ext_valid` is low.
- R2: With `elem16`=0, a lane-wise MAC (`op_code`=0) adds the signed product of byte i of `a_vec` and byte i of `b_vec` into 32-bit wide-accumulator lane i (bits 32i+31..32i), modulo 2^32.
- R3: With `elem16`=1, a lane-wise MAC adds the signed product of halfword j of both operands into 64-bit lane j (bits 64j+63..64j), modulo 2^64.
- R4: A scalar MAC (`op_code`=1) works like a lane-wise MAC, except that every lane uses element `sel` of `b_vec`. That is byte `sel` when `elem16`=0, and halfword `sel[2:0]` when `elem16`=1.
- R5: A dot MAC (`op_code`=2) adds the sum of the eight signed 16x16 halfword products into `xacc`, modulo 2^40, and leaves the wide accumulator unchanged.
- R6: `clr_wide` zeroes all 512 accumulator bits at the next edge and takes precedence over a MAC in the same cycle.
- R7: `clr_dot` zeroes `xacc` at the next edge and takes precedence over a dot MAC in the same cycle.
- R8: An extract (`op_code`=3) raises `ext_valid` for one cycle on the next edge. In the same cycle, `ext_vec` element k holds accumulator lane k shifted arithmetically right by `shamt` and saturated to the signed element range. The extract uses the accumulator state from before that edge and does not alter the accumulator.
- R9: When `op_valid` is low and no clear is asserted, both accumulators keep their values, `ext_valid` is low and `ext_vec` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 2 | 0 lane MAC, 1 scalar MAC, 2 dot MAC, 3 extract |
| elem16 | input | 1 | Element width: 0 = 8-bit, 1 = 16-bit |
| sel | input | 4 | Broadcast element index for scalar MAC |
| shamt | input | 6 | Right-shift amount for extract |
| a_vec | input | 128 | First operand vector |
| b_vec | input | 128 | Second operand vector |
| clr_wide | input | 1 | Zero the wide accumulator |
| clr_dot | input | 1 | Zero the scalar accumulator |
| ext_vec | output | 128 | Narrowed extract result |
| ext_valid | output | 1 | Extract result valid, one cycle |
| xacc | output | 40 | Scalar dot-product accumulator |

## Verification
The assertions assume that `op_valid`, `op_code` and the clear strobes hold settled, known values at each rising edge. They also assume that `clr_wide` is the only thing that changes the wide accumulator outside a MAC. The bench drives every input on the falling edge and keeps `elem16` fixed between wide clears, because the accumulator's meaning depends on the element width. Random phases mix all four commands with occasional clears, some of them colliding with a MAC.

// File: rtl/vmac_pkg.sv
// Package: shared command encoding and sizing for the vector MAC accumulator.
// Assumes: users cast the 2-bit op_code port into vop_e.
package vmac_pkg;
    typedef enum logic [1:0] {
        VOP_MAC_VEC = 2'd0,
        VOP_MAC_SCL = 2'd1,
        VOP_MAC_DOT = 2'd2,
        VOP_EXTRACT = 2'd3
    } vop_e;

    localparam int VEC_W_DEF = 128;
    localparam int XACC_W_DEF = 40;
    localparam int SH_W_DEF = 6;
endpackage

// File: rtl/vmac_prod.sv
// Module: vmac_prod
// Forms every signed 8x8 and 16x16 lane product of the two operands.
// When bcast is set, the b element picked by sel replaces every b lane.
// Assumes: VEC_W is a multiple of 16. Purely combinational.
module vmac_prod #(
    parameter int VEC_W = 128,
    localparam int N8 = VEC_W / 8,
    localparam int N16 = VEC_W / 16,
    localparam int SEL_W = $clog2(N8)
) (
    input  logic [VEC_W-1:0]   a_vec,
    input  logic [VEC_W-1:0]   b_vec,
    input  logic               bcast,
    input  logic [SEL_W-1:0]   sel,
    output logic [N8*16-1:0]   prod8,
    output logic [N16*32-1:0]  prod16
);
    logic [7:0]  b8_pick;
    logic [15:0] b16_pick;

    // Pick the broadcast element for each element width.
    always_comb begin
        b8_pick  = b_vec[8*sel +: 8];
        b16_pick = b_vec[16*sel[SEL_W-2:0] +: 16];
    end

    for (genvar i = 0; i < N8; i++) begin : g_p8
        logic [7:0] bop;
        // Select the lane or broadcast operand, then multiply signed.
        always_comb begin
            bop = bcast ? b8_pick : b_vec[8*i +: 8];
            prod8[16*i +: 16] = 16'($signed(a_vec[8*i +: 8]) * $signed(bop));
        end
    end

    for (genvar j = 0; j < N16; j++) begin : g_p16
        logic [15:0] bop;
        // Select the lane or broadcast operand, then multiply signed.
        always_comb begin
            bop = bcast ? b16_pick : b_vec[16*j +: 16];
            prod16[32*j +: 32] = 32'($signed(a_vec[16*j +: 16]) * $signed(bop));
        end
    end
endmodule

// File: rtl/vmac_wide_acc.sv
// Module: vmac_wide_acc
// Holds the 4*VEC_W-bit accumulator. Its lane split follows the element width:
// N8 lanes of 4*8 bits or N16 lanes of 4*16 bits, each wrapping on overflow.
// Assumes: clr has priority over acc_en. The split is only meaningful
// when elem16 is unchanged since the last clear.
module vmac_wide_acc #(
    parameter int VEC_W = 128,
    localparam int ACC_W = 4 * VEC_W,
    localparam int N8 = VEC_W / 8,
    localparam int N16 = VEC_W / 16,
    localparam int L8 = ACC_W / N8,
    localparam int L16 = ACC_W / N16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               acc_en,
    input  logic               elem16,
    input  logic [N8*16-1:0]   prod8,
    input  logic [N16*32-1:0]  prod16,
    output logic [ACC_W-1:0]   acc
);
    logic [ACC_W-1:0] nxt8;
    logic [ACC_W-1:0] nxt16;

    for (genvar i = 0; i < N8; i++) begin : g_a8
        // Add the sign-extended byte product into its narrow lane.
        always_comb nxt8[L8*i +: L8] = acc[L8*i +: L8] + L8'($signed(prod8[16*i +: 16]));
    end

    for (genvar j = 0; j < N16; j++) begin : g_a16
        // Add the sign-extended halfword product into its wide lane.
        always_comb nxt16[L16*j +: L16] = acc[L16*j +: L16] + L16'($signed(prod16[32*j +: 32]));
    end

    // Accumulator register: reset, clear, or accumulate at the selected split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= elem16 ? nxt16 : nxt8;
        end
    end

    AST_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0)); // R6
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc_en) |=> $stable(acc)); // R9
endmodule

// File: rtl/vmac_dot_acc.sv
// Module: vmac_dot_acc
// Scalar dot-product accumulator: adds the sum of all halfword lane products
// into an XW-bit register, modulo 2^XW.
// Assumes: clr has priority over en. Products arrive already signed and 32 bits wide.
module vmac_dot_acc #(
    parameter int N16 = 8,
    parameter int XW = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [N16*32-1:0]  prod16,
    output logic [XW-1:0]      xacc
);
    logic [XW-1:0] lane_sum;

    // Reduce all lane products to one sign-extended sum.
    always_comb begin
        lane_sum = '0;
        for (int j = 0; j < N16; j++) begin
            lane_sum = lane_sum + XW'($signed(prod16[32*j +: 32]));
        end
    end

    // Scalar accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xacc <= '0;
        end else if (clr) begin
            xacc <= '0;
        end else if (en) begin
            xacc <= xacc + lane_sum;
        end
    end

    AST_DOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (xacc == '0)); // R7
    AST_DOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(xacc)); // R9
endmodule

// File: rtl/vmac_extract.sv
// Module: vmac_extract
// Shifts each accumulator lane arithmetically right by shamt and saturates
// it to the signed element range. The results are packed into one vector.
// Assumes: elem16 matches the split used while accumulating. Combinational.
module vmac_extract #(
    parameter int VEC_W = 128,
    parameter int SH_W = 6,
    localparam int ACC_W = 4 * VEC_W,
    localparam int N8 = VEC_W / 8,
    localparam int N16 = VEC_W / 16,
    localparam int L8 = ACC_W / N8,
    localparam int L16 = ACC_W / N16
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic              elem16,
    input  logic [SH_W-1:0]   shamt,
    output logic [VEC_W-1:0]  vec
);
    localparam logic signed [L8-1:0]  HI8  = {{(L8-7){1'b0}}, {7{1'b1}}};
    localparam logic signed [L8-1:0]  LO8  = ~HI8;
    localparam logic signed [L16-1:0] HI16 = {{(L16-15){1'b0}}, {15{1'b1}}};
    localparam logic signed [L16-1:0] LO16 = ~HI16;

    logic [VEC_W-1:0] v8;
    logic [VEC_W-1:0] v16;

    for (genvar i = 0; i < N8; i++) begin : g_x8
        logic signed [L8-1:0] shv;
        // Shift one narrow lane and clamp it to a signed byte.
        always_comb begin
            shv = $signed(acc[L8*i +: L8]) >>> shamt;
            if (shv > HI8)      v8[8*i +: 8] = HI8[7:0];
            else if (shv < LO8) v8[8*i +: 8] = LO8[7:0];
            else                v8[8*i +: 8] = shv[7:0];
        end
    end

    for (genvar j = 0; j < N16; j++) begin : g_x16
        logic signed [L16-1:0] shv;
        // Shift one wide lane and clamp it to a signed halfword.
        always_comb begin
            shv = $signed(acc[L16*j +: L16]) >>> shamt;
            if (shv > HI16)      v16[16*j +: 16] = HI16[15:0];
            else if (shv < LO16) v16[16*j +: 16] = LO16[15:0];
            else                 v16[16*j +: 16] = shv[15:0];
        end
    end

    // Choose the packing that matches the element width.
    always_comb vec = elem16 ? v16 : v8;
endmodule

// File: rtl/vmac_accum.sv
// Module: vmac_accum (top)
// Vector MAC engine: decodes one command per cycle into the product array,
// the wide and scalar accumulators, and a registered extract result.
// Assumes: inputs are stable at the rising edge. The clears act independently
// of op_valid and override an accumulate in the same cycle.
module vmac_accum
    import vmac_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF,
    parameter int XACC_W = XACC_W_DEF,
    parameter int SH_W = SH_W_DEF,
    localparam int N8 = VEC_W / 8,
    localparam int N16 = VEC_W / 16,
    localparam int SEL_W = $clog2(N8),
    localparam int ACC_W = 4 * VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              elem16,
    input  logic [SEL_W-1:0]  sel,
    input  logic [SH_W-1:0]   shamt,
    input  logic [VEC_W-1:0]  a_vec,
    input  logic [VEC_W-1:0]  b_vec,
    input  logic              clr_wide,
    input  logic              clr_dot,
    output logic [VEC_W-1:0]  ext_vec,
    output logic              ext_valid,
    output logic [XACC_W-1:0] xacc
);
    vop_e                op;
    logic                mac_en;
    logic                dot_en;
    logic                ext_en;
    logic                bcast;
    logic [N8*16-1:0]    prod8;
    logic [N16*32-1:0]   prod16;
    logic [ACC_W-1:0]    wide_acc;
    logic [VEC_W-1:0]    ext_nxt;

    // Command decode.
    always_comb begin
        op     = vop_e'(op_code);
        mac_en = op_valid && (op == VOP_MAC_VEC || op == VOP_MAC_SCL);
        dot_en = op_valid && (op == VOP_MAC_DOT);
        ext_en = op_valid && (op == VOP_EXTRACT);
        bcast  = (op == VOP_MAC_SCL);
    end

    vmac_prod #(.VEC_W(VEC_W)) u_prod (
        .a_vec  (a_vec),
        .b_vec  (b_vec),
        .bcast  (bcast),
        .sel    (sel),
        .prod8  (prod8),
        .prod16 (prod16)
    );

    vmac_wide_acc #(.VEC_W(VEC_W)) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_wide),
        .acc_en (mac_en),
        .elem16 (elem16),
        .prod8  (prod8),
        .prod16 (prod16),
        .acc    (wide_acc)
    );

    vmac_dot_acc #(.N16(N16), .XW(XACC_W)) u_dot (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_dot),
        .en     (dot_en),
        .prod16 (prod16),
        .xacc   (xacc)
    );

    vmac_extract #(.VEC_W(VEC_W), .SH_W(SH_W)) u_ext (
        .acc    (wide_acc),
        .elem16 (elem16),
        .shamt  (shamt),
        .vec    (ext_nxt)
    );

    // Register the extract result and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_vec   <= '0;
            ext_valid <= 1'b0;
        end else begin
            ext_valid <= ext_en;
            if (ext_en) ext_vec <= ext_nxt;
        end
    end

    AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en |=> ext_valid); // R8
    AST_EXT_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !clr_wide) |=> $stable(wide_acc)); // R8
    AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> (!ext_valid && $stable(ext_vec))); // R9
endmodule

// File: tb/vmac_accum_test.sv
// Bench for vmac_accum: directed corner cases plus seeded random commands,
// checked against a bench-side model of both accumulators.
module vmac_accum_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [1:0]   op_code;
    logic         elem16;
    logic [3:0]   sel;
    logic [5:0]   shamt;
    logic [127:0] a_vec, b_vec;
    logic         clr_wide, clr_dot;
    logic [127:0] ext_vec;
    logic         ext_valid;
    logic [39:0]  xacc;

    int checks = 0;
    int failures = 0;
    logic [511:0] m_wide;
    logic [39:0]  m_x;
    logic [127:0] m_ext;

    always #4 clk = ~clk;

    vmac_accum uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .elem16(elem16), .sel(sel), .shamt(shamt), .a_vec(a_vec), .b_vec(b_vec),
        .clr_wide(clr_wide), .clr_dot(clr_dot), .ext_vec(ext_vec),
        .ext_valid(ext_valid), .xacc(xacc)
    );

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] mac_model(input logic [511:0] w, input logic e16,
        input logic scl, input logic [127:0] a, input logic [127:0] b, input logic [3:0] s);
        logic [511:0] r = w;
        if (!e16) begin
            for (int i = 0; i < 16; i++) begin
                logic [7:0] bb = scl ? b[8*s +: 8] : b[8*i +: 8];
                int p = int'(byte'(a[8*i +: 8])) * int'(byte'(bb));
                r[32*i +: 32] = r[32*i +: 32] + 32'(p);
            end
        end else begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] bb = scl ? b[16*s[2:0] +: 16] : b[16*j +: 16];
                longint p = longint'(shortint'(a[16*j +: 16])) * longint'(shortint'(bb));
                r[64*j +: 64] = r[64*j +: 64] + 64'(p);
            end
        end
        return r;
    endfunction

    function automatic logic [39:0] dot_model(input logic [39:0] x,
        input logic [127:0] a, input logic [127:0] b);
        longint sum = 0;
        for (int j = 0; j < 8; j++)
            sum += longint'(shortint'(a[16*j +: 16])) * longint'(shortint'(b[16*j +: 16]));
        return x + 40'(sum);
    endfunction

    function automatic logic [127:0] ext_model(input logic [511:0] w, input logic e16,
        input logic [5:0] sh);
        logic [127:0] r;
        if (!e16) begin
            for (int i = 0; i < 16; i++) begin
                int v = int'(w[32*i +: 32]) >>> sh;
                r[8*i +: 8] = (v > 127) ? 8'h7f : (v < -128) ? 8'h80 : 8'(v);
            end
        end else begin
            for (int j = 0; j < 8; j++) begin
                longint v = longint'(w[64*j +: 64]) >>> sh;
                r[16*j +: 16] = (v > 32767) ? 16'h7fff : (v < -32768) ? 16'h8000 : 16'(v);
            end
        end
        return r;
    endfunction

    // Drive one command at the falling edge, then check after the next rising edge.
    task automatic run_op(input string tag, input logic v, input logic [1:0] op,
        input logic e16, input logic [127:0] a, input logic [127:0] b,
        input logic [3:0] s, input logic [5:0] sh, input logic cw, input logic cd);
        logic is_ext = v && (op == 2'd3);
        string xtag;
        op_valid = v; op_code = op; elem16 = e16; a_vec = a; b_vec = b;
        sel = s; shamt = sh; clr_wide = cw; clr_dot = cd;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; clr_wide = 1'b0; clr_dot = 1'b0;
        if (is_ext) m_ext = ext_model(m_wide, e16, sh);
        if (cw) m_wide = '0;
        else if (v && (op == 2'd0 || op == 2'd1)) m_wide = mac_model(m_wide, e16, op == 2'd1, a, b, s);
        xtag = cd ? "R7" : (v && op == 2'd2) ? "R5" : "R9";
        if (cd) m_x = '0;
        else if (v && op == 2'd2) m_x = dot_model(m_x, a, b);
        chk(xtag, {88'd0, xacc}, {88'd0, m_x});
        chk(is_ext ? tag : "R9", {127'd0, ext_valid}, {127'd0, is_ext});
        chk(is_ext ? tag : "R9", ext_vec, m_ext);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_valid = 0; op_code = 0; elem16 = 0; sel = 0; shamt = 0;
        a_vec = '0; b_vec = '0; clr_wide = 0; clr_dot = 0;
        m_wide = '0; m_x = '0; m_ext = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1", ext_vec, '0);
        chk("R1", {127'd0, ext_valid}, '0);
        chk("R1", {88'd0, xacc}, '0);
        run_op("R1", 1, 2'd3, 0, '0, '0, 0, 0, 0, 0);

        // R2: lane-wise byte MAC, small values, then read back unshifted
        begin
            logic [127:0] a, b;
            for (int i = 0; i < 16; i++) begin a[8*i +: 8] = 8'(i - 8); b[8*i +: 8] = 8'(3); end
            run_op("R2", 1, 2'd0, 0, a, b, 0, 0, 0, 0);
            run_op("R2", 1, 2'd0, 0, a, b, 0, 0, 0, 0);
            run_op("R2", 1, 2'd3, 0, '0, '0, 0, 0, 0, 0);
            // R4: byte broadcast of element 5
            run_op("R4", 1, 2'd1, 0, a, b ^ {8'd0, 8'd9, 80'd0, 8'h80, 32'd0}, 5, 0, 0, 0);
            run_op("R4", 1, 2'd3, 0, '0, '0, 0, 2, 0, 0);
        end
        // R6: clear collides with a MAC; clear wins
        run_op("R6", 1, 2'd0, 0, rnd128(), rnd128(), 0, 0, 1, 0);
        run_op("R6", 1, 2'd3, 0, '0, '0, 0, 0, 0, 0);

        // R8: saturation at both ends with 8-bit lanes
        begin
            logic [127:0] a, b;
            for (int i = 0; i < 16; i++) begin
                a[8*i +: 8] = 8'h80; b[8*i +: 8] = (i < 8) ? 8'h80 : 8'h7f;
            end
            run_op("R8", 1, 2'd0, 0, a, b, 0, 0, 0, 0);
            run_op("R8", 1, 2'd3, 0, '0, '0, 0, 0, 0, 0);
            run_op("R8", 1, 2'd3, 0, '0, '0, 0, 63, 0, 0);
            run_op("R8", 1, 2'd3, 0, '0, '0, 0, 8, 0, 0);
        end

        // R3: halfword lanes after a clear
        run_op("R3", 0, 2'd0, 1, '0, '0, 0, 0, 1, 0);
        begin
            logic [127:0] a, b;
            for (int j = 0; j < 8; j++) begin a[16*j +: 16] = 16'(j * 100 - 350); b[16*j +: 16] = 16'(-7); end
            run_op("R3", 1, 2'd0, 1, a, b, 0, 0, 0, 0);
            run_op("R3", 1, 2'd3, 1, '0, '0, 0, 0, 0, 0);
            // R4: halfword broadcast of element 6 (sel upper bit ignored)
            b[16*6 +: 16] = 16'h8000;
            run_op("R4", 1, 2'd1, 1, a, b, 4'hE, 0, 0, 0);
            run_op("R4", 1, 2'd3, 1, '0, '0, 0, 20, 0, 0);
        end

        // R5: dot product wrap at 2^40 after 130 maximal MACs
        for (int k = 0; k < 130; k++)
            run_op("R5", 1, 2'd2, 1, {8{16'h8000}}, {8{16'h8000}}, 0, 0, 0, 0);
        chk("R5", {88'd0, xacc}, {88'd0, 40'h4_0000_0000});
        // R7: clear collides with a dot MAC
        run_op("R7", 1, 2'd2, 1, rnd128(), rnd128(), 0, 0, 0, 1);
        // R9: idle cycles keep everything
        run_op("R9", 0, 2'd0, 1, rnd128(), rnd128(), 0, 0, 0, 0);
        run_op("R9", 0, 2'd3, 1, rnd128(), rnd128(), 0, 0, 0, 0);

        // Random phases, one per element width
        for (int ph = 0; ph < 2; ph++) begin
            run_op("R6", 0, 2'd0, ph[0], '0, '0, 0, 0, 1, 1);
            for (int k = 0; k < 400; k++) begin
                logic [1:0] op = 2'($urandom_range(0, 3));
                logic v = ($urandom_range(0, 7) != 0);
                logic cw = ($urandom_range(0, 31) == 0);
                logic cd = ($urandom_range(0, 31) == 0);
                run_op("R8", v, op, ph[0], rnd128(), rnd128(), 4'($urandom_range(0, 15)),
                       6'($urandom_range(0, 63)), cw, cd);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule